// File: doc/BRIEF.md
# EDO DRAM Page-Mode Controller

This block is a synchronous controller for a 256K x 16 extended-data-out DRAM with a multiplexed 9-bit address bus. A host hands it one request at a time through a ready/valid port. Each request carries an 18-bit word address, a write flag, two byte enables and 16 bits of write data. The controller splits the address into a row and a column. It opens the row with the row strobe and then runs column cycles with the upper and lower column strobes. Read data comes back on a one-cycle valid strobe.

Once a row is open it stays open. Later requests to the same row run as page-mode column cycles with no new activation. A request to another row, a write that follows a read in the open page, a refresh grant from the separate refresh arbiter, or the approach of the row-strobe pulse limit each close the page first. Closing means raising the row strobe and waiting out the precharge time. Every DRAM timing is a parameter counted in clock cycles.

Read data is sampled a fixed number of cycles after the column strobe falls. The device keeps its output valid while the row strobe and output enable stay low and write enable stays high. The sample may therefore fall inside the column precharge.

Top module: `edo_page_ctrl`

## Requirements
- R1: After reset the row strobe, both column strobes, write enable and output enable are high, the data bus is not driven, `rd_valid` is low and `req_ready` is high.
- R2: `req_addr[17:9]` is the row and `req_addr[8:0]` is the column. The row is on `dram_addr` when the row strobe falls and the column is on it when a column strobe falls, so data written to an address reads back from the same address only.
- R3: `req_be[1]` selects the upper column strobe and bits 15:8, and `req_be[0]` selects the lower column strobe and bits 7:0. Enabled strobes fall in the same cycle, and neither falls while the other is already low. On a read, disabled lanes of `rd_data` are zero.
- R4: A request to the open row, other than a write after a read, runs as a page-mode column cycle with no new row activation.
- R5: A request to a different row, or a write that follows a read in the open page, raises the row strobe and holds it high for at least `T_RP` cycles, then activates the requested row.
- R6: A column strobe falls at least `T_RCD` cycles after the row strobe falls. It stays low for exactly `T_CAS` cycles and stays high for at least `T_CP` cycles between column cycles. A column strobe is low only while the row strobe is low.
- R7: For a write, write enable is low at least one cycle before the column strobe falls and stays low while it is low. The controller drives the data bus only while output enable is high.
- R8: A read returns, on a one-cycle `rd_valid` pulse, the device data sampled `T_CAC` cycles after the column strobe falls. A write produces no `rd_valid`.
- R9: The row strobe is never low for more than `T_RASMAX` cycles. Once the limit is near, the page is closed even if hits continue.
- R10: While `refresh_grant` is high, `req_ready` is low, no request is accepted and an open page is closed, so the row strobe stays high.
- R11: `req_ready` is high only while the controller waits in the idle or open-page state. It drops in the cycle after a handshake.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller accepts a request this cycle |
| req_addr | input | 18 | Word address, row in 17:9, column in 8:0 |
| req_we | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte enables, bit 1 upper, bit 0 lower |
| req_wdata | input | 16 | Write data |
| rd_valid | output | 1 | Read data strobe, one cycle |
| rd_data | output | 16 | Read data, disabled lanes zero |
| refresh_grant | input | 1 | Refresh arbiter owns the device |
| dram_addr | output | 9 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_ucas_n | output | 1 | Upper column strobe, active low |
| dram_lcas_n | output | 1 | Lower column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 16 | Write data to the device |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |
| dram_dq_in | input | 16 | Data from the device |

## Verification
A wrong phase counter shows up in the cycle of the next strobe edge. It appears as a column strobe too close to the row strobe, a column pulse of the wrong length, or a precharge that is too short. A stale open-row record or page-open flag shows up at the next request, as a missing or extra row activation. A lane or address mix-up shows up at the first read-back of written data, with wrong bytes or a non-zero masked lane. A broken pulse-limit counter or refresh gating shows up only over a long run of hits, or while a grant is held, as a row strobe that stays low.

// File: rtl/edo_pkg.sv
package edo_pkg;
    parameter int MA_W   = 9;
    parameter int ADDR_W = 2 * MA_W;
    parameter int LANE_W = 8;
    parameter int LANES  = 2;
    parameter int DQ_W   = LANE_W * LANES;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACT,
        ST_COLSET,
        ST_CAS,
        ST_CP,
        ST_OPEN,
        ST_PRE
    } edo_st_e;
endpackage

// File: rtl/edo_ras_window.sv
module edo_ras_window #(
    parameter int T_RASMAX = 9000,
    parameter int GUARD    = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ras_low,
    output logic near_limit
);
    localparam int RW    = $clog2(T_RASMAX + 1);
    localparam int LIMIT = T_RASMAX - GUARD;

    logic [RW-1:0] run_d, run_q;

    always_comb begin
        run_d = run_q;
        if (!ras_low)
            run_d = '0;
        else if (run_q != RW'(T_RASMAX))
            run_d = run_q + RW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end

    assign near_limit = ras_low && (run_q >= RW'(LIMIT));

    // R9
    ras_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ras_low |-> (run_q < RW'(T_RASMAX)));
endmodule

// File: rtl/edo_rd_capture.sv
module edo_rd_capture import edo_pkg::*; (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en,
    input  logic [LANES-1:0] lane_en,
    input  logic [DQ_W-1:0]  dq_in,
    output logic             rd_valid,
    output logic [DQ_W-1:0]  rd_data
);
    logic [DQ_W-1:0] mask;
    logic            vld_d, vld_q;
    logic [DQ_W-1:0] dat_d, dat_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign mask[g*LANE_W +: LANE_W] = {LANE_W{lane_en[g]}};
    end

    always_comb begin
        vld_d = cap_en;
        dat_d = dat_q;
        if (cap_en) dat_d = dq_in & mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            dat_q <= '0;
        end else begin
            vld_q <= vld_d;
            dat_q <= dat_d;
        end
    end

    assign rd_valid = vld_q;
    assign rd_data  = dat_q;
endmodule

// File: rtl/edo_page_ctrl.sv
module edo_page_ctrl import edo_pkg::*; #(
    parameter int T_RCD    = 2,
    parameter int T_CAS    = 2,
    parameter int T_CP     = 1,
    parameter int T_RP     = 2,
    parameter int T_CAC    = 2,
    parameter int T_RASMAX = 9000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_we,
    input  logic [LANES-1:0]  req_be,
    input  logic [DQ_W-1:0]   req_wdata,
    output logic              rd_valid,
    output logic [DQ_W-1:0]   rd_data,
    input  logic              refresh_grant,
    output logic [MA_W-1:0]   dram_addr,
    output logic              dram_ras_n,
    output logic              dram_ucas_n,
    output logic              dram_lcas_n,
    output logic              dram_we_n,
    output logic              dram_oe_n,
    output logic [DQ_W-1:0]   dram_dq_out,
    output logic              dram_dq_oe,
    input  logic [DQ_W-1:0]   dram_dq_in
);
    localparam int MAXT_A = (T_RCD > T_CAS) ? T_RCD : T_CAS;
    localparam int MAXT_B = (T_CP > T_RP) ? T_CP : T_RP;
    localparam int MAXT   = (MAXT_A > MAXT_B) ? MAXT_A : MAXT_B;
    localparam int CW     = $clog2(MAXT + 1);
    localparam int PW     = $clog2(T_CAS + T_CP + 1);
    localparam int GUARD  = T_CAS + T_CP + 3;

    typedef struct packed {
        edo_st_e          st;
        logic [CW-1:0]    cnt;
        logic [PW-1:0]    ph;
        logic [MA_W-1:0]  row;
        logic [MA_W-1:0]  col;
        logic             wr;
        logic [LANES-1:0] be;
        logic [DQ_W-1:0]  wd;
        logic             pend;
        logic             last_rd;
        logic             ras_n;
        logic             ucas_n;
        logic             lcas_n;
        logic             we_n;
        logic             oe_n;
        logic [MA_W-1:0]  ma;
        logic             dq_oe;
    } ctl_t;

    ctl_t q, n;
    logic cap_en, near_limit, accept, row_hit;
    logic [MA_W-1:0] in_row, in_col;

    assign in_row    = req_addr[ADDR_W-1:MA_W];
    assign in_col    = req_addr[MA_W-1:0];
    assign req_ready = (q.st == ST_IDLE || q.st == ST_OPEN) && !refresh_grant && !near_limit;
    assign accept    = req_valid && req_ready;
    assign row_hit   = (in_row == q.row) && !(req_we && q.last_rd);

    always_comb begin
        n      = q;
        cap_en = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (accept) begin
                    n.row   = in_row;
                    n.col   = in_col;
                    n.wr    = req_we;
                    n.be    = req_be;
                    n.wd    = req_wdata;
                    n.st    = ST_ACT;
                    n.ras_n = 1'b0;
                    n.ma    = in_row;
                    n.we_n  = ~req_we;
                    n.dq_oe = req_we;
                    n.oe_n  = 1'b1;
                    n.cnt   = CW'(T_RCD - 1);
                end
            end
            ST_ACT, ST_COLSET: begin
                if (q.st == ST_COLSET || q.cnt == '0) begin
                    n.st     = ST_CAS;
                    n.ma     = q.col;
                    n.ucas_n = ~q.be[1];
                    n.lcas_n = ~q.be[0];
                    n.oe_n   = q.wr;
                    n.ph     = '0;
                    n.cnt    = CW'(T_CAS - 1);
                end else begin
                    n.cnt = q.cnt - CW'(1);
                end
            end
            ST_CAS, ST_CP: begin
                n.ph   = q.ph + PW'(1);
                cap_en = !q.wr && (q.ph == PW'(T_CAC - 1));
                if (q.cnt != '0) begin
                    n.cnt = q.cnt - CW'(1);
                end else if (q.st == ST_CAS) begin
                    n.st     = ST_CP;
                    n.ucas_n = 1'b1;
                    n.lcas_n = 1'b1;
                    n.we_n   = 1'b1;
                    n.dq_oe  = 1'b0;
                    n.cnt    = CW'(T_CP - 1);
                end else begin
                    n.st      = ST_OPEN;
                    n.last_rd = !q.wr;
                end
            end
            ST_OPEN: begin
                if (accept) begin
                    n.row = in_row;
                    n.col = in_col;
                    n.wr  = req_we;
                    n.be  = req_be;
                    n.wd  = req_wdata;
                    if (row_hit) begin
                        n.st    = ST_COLSET;
                        n.ma    = in_col;
                        n.we_n  = ~req_we;
                        n.dq_oe = req_we;
                        if (req_we) n.oe_n = 1'b1;
                    end else begin
                        n.st    = ST_PRE;
                        n.ras_n = 1'b1;
                        n.oe_n  = 1'b1;
                        n.pend  = 1'b1;
                        n.cnt   = CW'(T_RP - 1);
                    end
                end else if (refresh_grant || near_limit) begin
                    n.st    = ST_PRE;
                    n.ras_n = 1'b1;
                    n.oe_n  = 1'b1;
                    n.pend  = 1'b0;
                    n.cnt   = CW'(T_RP - 1);
                end
            end
            ST_PRE: begin
                if (q.cnt != '0) begin
                    n.cnt = q.cnt - CW'(1);
                end else if (!q.pend) begin
                    n.st = ST_IDLE;
                end else if (!refresh_grant) begin
                    n.st    = ST_ACT;
                    n.pend  = 1'b0;
                    n.ras_n = 1'b0;
                    n.ma    = q.row;
                    n.we_n  = ~q.wr;
                    n.dq_oe = q.wr;
                    n.cnt   = CW'(T_RCD - 1);
                end
            end
            default: n.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q        <= '0;
            q.st     <= ST_IDLE;
            q.ras_n  <= 1'b1;
            q.ucas_n <= 1'b1;
            q.lcas_n <= 1'b1;
            q.we_n   <= 1'b1;
            q.oe_n   <= 1'b1;
        end else begin
            q <= n;
        end
    end

    edo_ras_window #(.T_RASMAX(T_RASMAX), .GUARD(GUARD)) u_window (
        .clk(clk), .rst_n(rst_n), .ras_low(!q.ras_n), .near_limit(near_limit));

    edo_rd_capture u_capture (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .lane_en(q.be),
        .dq_in(dram_dq_in), .rd_valid(rd_valid), .rd_data(rd_data));

    assign dram_addr   = q.ma;
    assign dram_ras_n  = q.ras_n;
    assign dram_ucas_n = q.ucas_n;
    assign dram_lcas_n = q.lcas_n;
    assign dram_we_n   = q.we_n;
    assign dram_oe_n   = q.oe_n;
    assign dram_dq_out = q.wd;
    assign dram_dq_oe  = q.dq_oe;

    initial begin
        // R8
        cac_window_chk: assert (T_CAC >= 1 && T_CAC <= T_CAS + T_CP);
        // R9
        rasmax_room_chk: assert (T_RASMAX >= T_RCD + 2 * GUARD);
    end

    // R3
    lane_sync_u_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.ucas_n) |-> $past(q.lcas_n));
    // R3
    lane_sync_l_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.lcas_n) |-> $past(q.ucas_n));
    // R7
    we_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.we_n && ($fell(q.ucas_n) || $fell(q.lcas_n))) |-> !$past(q.we_n));
    // R7
    bus_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.dq_oe |-> q.oe_n);
    // R6
    cas_in_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.ucas_n || !q.lcas_n) |-> !q.ras_n);
    // R11
    one_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
endmodule

// File: tb/edo_page_ctrl_test.sv
module edo_page_ctrl_test;
    localparam int T_RCD = 2, T_CAS = 2, T_CP = 1, T_RP = 2, T_CAC = 2, T_RASMAX = 120;

    typedef struct packed {
        logic [17:0] addr;
        logic        we;
        logic [1:0]  be;
        logic [15:0] wd;
        logic [15:0] exp;
        logic        act;
    } vec_t;

    localparam vec_t VECS [13] = '{
        '{18'h00607, 1'b1, 2'b11, 16'h1234, 16'h0000, 1'b1},
        '{18'h00608, 1'b1, 2'b11, 16'h5678, 16'h0000, 1'b0},
        '{18'h00607, 1'b0, 2'b11, 16'h0000, 16'h1234, 1'b0},
        '{18'h00608, 1'b0, 2'b11, 16'h0000, 16'h5678, 1'b0},
        '{18'h00607, 1'b1, 2'b10, 16'hABCD, 16'h0000, 1'b1},
        '{18'h00607, 1'b0, 2'b11, 16'h0000, 16'hAB34, 1'b0},
        '{18'h01207, 1'b1, 2'b01, 16'h77EF, 16'h0000, 1'b1},
        '{18'h01207, 1'b0, 2'b11, 16'h0000, 16'h00EF, 1'b0},
        '{18'h00607, 1'b0, 2'b10, 16'h0000, 16'hAB00, 1'b1},
        '{18'h00607, 1'b0, 2'b01, 16'h0000, 16'h0034, 1'b0},
        '{18'h3FFFF, 1'b1, 2'b11, 16'hFFFF, 16'h0000, 1'b1},
        '{18'h3FFFF, 1'b0, 2'b11, 16'h0000, 16'hFFFF, 1'b0},
        '{18'h00000, 1'b0, 2'b11, 16'h0000, 16'h0000, 1'b1}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_we = 1'b0, refresh_grant = 1'b0;
    logic [17:0] req_addr = '0;
    logic [1:0]  req_be = '0;
    logic [15:0] req_wdata = '0, dram_dq_in = 16'hDEAD;
    logic req_ready, rd_valid, dram_ras_n, dram_ucas_n, dram_lcas_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [15:0] rd_data, dram_dq_out;
    logic [8:0]  dram_addr;

    int errors = 0, checks = 0, cycles = 0;

    edo_page_ctrl #(.T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP), .T_RP(T_RP),
                    .T_CAC(T_CAC), .T_RASMAX(T_RASMAX)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_we(req_we), .req_be(req_be), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .refresh_grant(refresh_grant),
        .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_ucas_n(dram_ucas_n),
        .dram_lcas_n(dram_lcas_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
        .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in));

    always #10 clk = ~clk;

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++; errors++;
            $display("FAIL watchdog: cycles %0d exp below 100000", cycles);
            finish_run();
        end
    end

    // device model and protocol monitor, sampled at negedge
    logic [15:0] mem [int];
    logic [8:0]  mrow;
    logic [15:0] mval;
    logic        mrd = 1'b0;
    logic p_ras = 1, p_u = 1, p_l = 1, p_we = 1;
    int act_cnt = 0, rdv_cnt = 0, ras_run = 0, ras_hi = 0, cas_run = 0, cas_gap = 0;
    int max_ras_run = 0, min_rcd = 1000, min_rp = 1000, min_cp = 1000;
    int cas_bad = 0, ew_bad = 0, stag_bad = 0, cont_bad = 0, rd_x = 0;
    logic [15:0] last_rd = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            automatic logic cas_now = !dram_ucas_n || !dram_lcas_n;
            automatic logic cas_prev = !p_u || !p_l;
            automatic int key;
            if (!dram_ras_n && p_ras) begin
                act_cnt++; mrow = dram_addr; ras_run = 0; cas_gap = -1;
                if (ras_hi < min_rp) min_rp = ras_hi;
            end
            if (!dram_ras_n) begin
                ras_run++; ras_hi = 0;
                if (ras_run > max_ras_run) max_ras_run = ras_run;
            end else begin
                ras_hi++; mrd = 1'b0;
            end
            if ((!dram_ucas_n && p_u && !p_l) || (!dram_lcas_n && p_l && !p_u)) stag_bad++;
            if (cas_now && !cas_prev) begin
                key = int'({mrow, dram_addr});
                if (ras_run - 1 < min_rcd) min_rcd = ras_run - 1;
                if (cas_gap >= 0 && cas_gap < min_cp) min_cp = cas_gap;
                cas_run = 0;
                if (!dram_we_n) begin
                    if (p_we) ew_bad++;
                    if (!mem.exists(key)) mem[key] = 16'h0000;
                    if (!dram_ucas_n) mem[key][15:8] = dram_dq_out[15:8];
                    if (!dram_lcas_n) mem[key][7:0] = dram_dq_out[7:0];
                    mrd = 1'b0;
                end else begin
                    mval = mem.exists(key) ? mem[key] : 16'h0000;
                    mrd = 1'b1;
                end
            end
            if (cas_now) begin
                cas_run++;
                if (p_we == 1'b0 && dram_we_n && cas_prev) ew_bad++;
            end
            if (!cas_now && cas_prev) begin
                if (cas_run != T_CAS) cas_bad++;
                cas_gap = 0;
            end
            if (!cas_now && cas_gap >= 0 && !dram_ras_n) cas_gap++;
            if (dram_dq_oe && !dram_oe_n) cont_bad++;
            if (rd_valid) begin rdv_cnt++; last_rd = rd_data; end
            dram_dq_in = (mrd && !dram_ras_n && !dram_oe_n) ? mval : 16'hDEAD;
            p_ras = dram_ras_n; p_u = dram_ucas_n; p_l = dram_lcas_n; p_we = dram_we_n;
        end
    end

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0h exp %0h", req, got, exp);
        end
    endtask

    task automatic do_req(input logic [17:0] ad, input logic we, input logic [1:0] be,
                          input logic [15:0] wd, output int acts, output int nrd,
                          output logic [15:0] rdat);
        int a0, r0, guard;
        @(negedge clk);
        req_addr = ad; req_we = we; req_be = be; req_wdata = wd; req_valid = 1'b1;
        a0 = act_cnt; r0 = rdv_cnt;
        guard = 0;
        while (!req_ready && guard < 500) begin @(negedge clk); guard++; end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        guard = 0;
        while (!req_ready && guard < 500) begin @(negedge clk); guard++; end
        @(negedge clk);
        if (guard >= 500) check("R11 ready return", 0, 1);
        acts = act_cnt - a0; nrd = rdv_cnt - r0; rdat = last_rd;
    endtask

    initial begin
        int acts, nrd, a0;
        logic [15:0] rdat;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 ras_n", dram_ras_n, 1);
        check("R1 cas_n", {dram_ucas_n, dram_lcas_n}, 2'b11);
        check("R1 we_n/oe_n", {dram_we_n, dram_oe_n}, 2'b11);
        check("R1 dq_oe", dram_dq_oe, 0);
        check("R1 rd_valid", rd_valid, 0);
        check("R1 ready", req_ready, 1);

        for (int i = 0; i < 13; i++) begin
            do_req(VECS[i].addr, VECS[i].we, VECS[i].be, VECS[i].wd, acts, nrd, rdat);
            // R4 hits, R5 misses and write-after-read
            check(VECS[i].act ? "R5 activation" : "R4 page hit", acts, int'(VECS[i].act));
            // R8 one strobe per read, none per write
            check("R8 rd_valid count", nrd, VECS[i].we ? 0 : 1);
            // R2 address map, R3 lane masking
            if (!VECS[i].we) check(VECS[i].be == 2'b11 ? "R2 read data" : "R3 lane data",
                                   rdat, VECS[i].exp);
        end

        // R10 refresh grant closes page and blocks requests
        @(negedge clk);
        refresh_grant = 1'b1;
        req_addr = 18'h00000; req_we = 1'b0; req_be = 2'b11; req_valid = 1'b1;
        a0 = act_cnt;
        repeat (2) @(negedge clk);
        check("R10 ready low", req_ready, 0);
        repeat (8) @(negedge clk);
        check("R10 ras high", dram_ras_n, 1);
        check("R10 no accept", act_cnt - a0, 0);
        req_valid = 1'b0;
        refresh_grant = 1'b0;
        do_req(18'h00000, 1'b0, 2'b11, 16'h0, acts, nrd, rdat);
        check("R10 reopen after grant", acts, 1);

        // R9 long run of hits must close the page
        a0 = act_cnt;
        for (int k = 0; k < 40; k++) do_req(18'h00607, 1'b0, 2'b11, 16'h0, acts, nrd, rdat);
        check("R9 forced close", (act_cnt - a0) > 0, 1);
        check("R9 max ras low", max_ras_run <= T_RASMAX, 1);
        check("R8 hammer data", rdat, 16'hAB34);

        // R6, R7, R3 protocol observations over the whole run
        check("R6 ras to cas", min_rcd >= T_RCD, 1);
        check("R6 cas width", cas_bad, 0);
        check("R6 cas precharge", min_cp >= T_CP, 1);
        check("R5 ras precharge", min_rp >= T_RP, 1);
        check("R7 early write", ew_bad, 0);
        check("R7 bus contention", cont_bad, 0);
        check("R3 lane stagger", stag_bad, 0);
        finish_run();
    end
endmodule